// File: doc/BRIEF.md
# Conditional Branch Resolver

This block resolves the conditional branch group of a 16-bit processor. For each request it decides whether the branch is taken and produces the next 24-bit program counter. For the counting branches it also produces a decremented register value with a write strobe. For the zero-test and compare branches it produces carry, zero and negative flag values with their own write strobe. The block does not fetch the address word and does not hold the register file. The issuing stage supplies:

- the opcode;
- a 4-bit flag or bit index;
- two register values;
- the flag register;
- the test register;
- the 16-bit branch address;
- the sequential PC, which already points past the two-word instruction.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream through one registered stage. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is taken. Results leave in the order their requests were accepted.

Top module: `branch_resolve_unit`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: An accepted request gives its result on the next cycle, with `out_valid` high. While `out_ready` is low, the result and `out_valid` are held unchanged. Results keep the order of acceptance.
- R3: Opcode 0x80 is taken when `in_flags[in_sel]` is 1, and opcode 0x81 is taken when that bit is 0. Neither opcode writes the register or the flags.
- R4: Opcode 0x82 is taken when `in_test[in_sel]` is 1, and opcode 0x83 is taken when that bit is 0. Neither opcode writes the register or the flags.
- R5: A taken branch gives `out_next_pc` = {`in_seq_pc[23:16]`, `in_addr`}. A branch that is not taken gives `out_next_pc` = `in_seq_pc`.
- R6: Opcode 0x84 is taken when `in_rs` is 0.
  - When it is not taken, `out_wr_en` is 1 and `out_wr_data` = `in_rs`-1.
  - The flags are written in both cases, with Z = (`in_rs`==0), N = `in_rs[15]` and C = 0.
- R7: Opcode 0x85 is taken when `in_rs` is nonzero.
  - When it is not taken, `out_wr_en` is 1 and `out_wr_data` is 0xFFFF.
  - The flags are written in both cases. Z = (`in_rs`==0) and N = `in_rs[15]`. C is 1 exactly when the decrement happened, because it borrowed.
- R8: Opcodes 0x86 and 0x87 are taken when `in_rs` equals `in_rs2` and when it differs, respectively. The flags come from `in_rs`-`in_rs2`: C is the borrow (`in_rs` < `in_rs2` unsigned), Z is equality, and N is bit 15 of the difference.
- R9: Opcode 0x88 is taken when `in_rs` > `in_rs2` and opcode 0x89 when `in_rs` >= `in_rs2`, both compared unsigned. The flags follow the R8 rule.
- R10: `out_flags_we` is 1 only for opcodes 0x84 to 0x89. Any opcode outside 0x80 to 0x89 is not taken and writes nothing.
- R11: `out_wr_data` is 0 whenever `out_wr_en` is 0. C, Z and N are 0 whenever `out_flags_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_opcode | input | 8 | Branch opcode |
| in_sel | input | 4 | Flag or test bit index |
| in_rs | input | 16 | First register value |
| in_rs2 | input | 16 | Second register value |
| in_flags | input | 16 | Flag register |
| in_test | input | 16 | Test register |
| in_addr | input | 16 | Branch address word |
| in_seq_pc | input | 24 | Sequential next PC |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result can be taken |
| out_taken | output | 1 | Branch taken |
| out_next_pc | output | 24 | Next program counter |
| out_wr_en | output | 1 | Write decremented register |
| out_wr_data | output | 16 | Decremented register value |
| out_flags_we | output | 1 | Write C, Z, N |
| out_c | output | 1 | Carry/borrow flag |
| out_z | output | 1 | Zero flag |
| out_n | output | 1 | Negative flag |

## Verification
The flag and bit branches are tried with index 0, an index in the middle and index 15, each in both polarities. This exposes swapped polarity and index slips. The counting branches get zero, one and 0x8000, which separates the taken decision, the 0xFFFF wrap with its borrow, and the sign-bit flag. The compare branches get equal, less and greater pairs, including 0x8000 against 0x0001, which separates unsigned from signed ordering. A PC whose upper byte is nonzero shows that a taken branch keeps that byte. An opcode outside the group and stretches of random output back-pressure check the idle result and that results keep their order while held.

// File: rtl/brx_pkg.sv
package brx_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned PC_W   = 24;
  localparam int unsigned SEL_W  = $clog2(DATA_W);

  localparam logic [7:0] OP_FLAG_SET = 8'h80;
  localparam logic [7:0] OP_FLAG_CLR = 8'h81;
  localparam logic [7:0] OP_TBIT_SET = 8'h82;
  localparam logic [7:0] OP_TBIT_CLR = 8'h83;
  localparam logic [7:0] OP_ZERO_DEC = 8'h84;
  localparam logic [7:0] OP_NZ_DEC   = 8'h85;
  localparam logic [7:0] OP_EQ       = 8'h86;
  localparam logic [7:0] OP_NE       = 8'h87;
  localparam logic [7:0] OP_GT       = 8'h88;
  localparam logic [7:0] OP_GE       = 8'h89;

  typedef struct packed {
    logic              taken;
    logic [PC_W-1:0]   next_pc;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic              flags_we;
    logic              c;
    logic              z;
    logic              n;
  } brx_result_t;
endpackage

// File: rtl/brx_cond.sv
module brx_cond
  import brx_pkg::*;
(
  input  logic [7:0]        opcode,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] rs,
  input  logic [DATA_W-1:0] rs2,
  input  logic [DATA_W-1:0] flags,
  input  logic [DATA_W-1:0] test,
  output logic              taken,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              flags_we,
  output logic              c,
  output logic              z,
  output logic              n
);
  // One shared subtractor: minus one for the counting group, minus rs2 for compares
  logic              dec_op;
  logic [DATA_W-1:0] sub_b;
  logic [DATA_W:0]   diff;
  logic              rs_zero;
  logic              borrow;
  logic              flag_bit;
  logic              test_bit;

  assign dec_op   = (opcode == OP_ZERO_DEC) || (opcode == OP_NZ_DEC);
  assign sub_b    = dec_op ? DATA_W'(1) : rs2;
  assign diff     = {1'b0, rs} - {1'b0, sub_b};
  assign borrow   = diff[DATA_W];
  assign rs_zero  = (rs == '0);
  assign flag_bit = flags[sel];
  assign test_bit = test[sel];

  always_comb begin
    taken    = 1'b0;
    wr_en    = 1'b0;
    wr_data  = '0;
    flags_we = 1'b0;
    c        = 1'b0;
    z        = 1'b0;
    n        = 1'b0;
    unique case (opcode)
      OP_FLAG_SET: taken = flag_bit;
      OP_FLAG_CLR: taken = !flag_bit;
      OP_TBIT_SET: taken = test_bit;
      OP_TBIT_CLR: taken = !test_bit;
      OP_ZERO_DEC, OP_NZ_DEC: begin
        taken    = (opcode == OP_ZERO_DEC) ? rs_zero : !rs_zero;
        wr_en    = !taken;
        wr_data  = taken ? '0 : diff[DATA_W-1:0];
        flags_we = 1'b1;
        z        = rs_zero;
        n        = rs[DATA_W-1];
        c        = !taken && borrow;
      end
      OP_EQ, OP_NE, OP_GT, OP_GE: begin
        flags_we = 1'b1;
        c        = borrow;
        z        = (diff[DATA_W-1:0] == '0);
        n        = diff[DATA_W-1];
        case (opcode)
          OP_EQ:   taken = z;
          OP_NE:   taken = !z;
          OP_GT:   taken = !c && !z;
          default: taken = !c;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/brx_target.sv
module brx_target
  import brx_pkg::*;
(
  input  logic              taken,
  input  logic [DATA_W-1:0] addr,
  input  logic [PC_W-1:0]   seq_pc,
  output logic [PC_W-1:0]   next_pc
);
  localparam int unsigned HI_W = PC_W - DATA_W;

  generate
    if (PC_W > DATA_W) begin : g_local_page
      assign next_pc = taken ? {seq_pc[PC_W-1 -: HI_W], addr} : seq_pc;
    end else begin : g_flat
      assign next_pc = taken ? addr[PC_W-1:0] : seq_pc;
    end
  endgenerate
endmodule

// File: rtl/brx_outreg.sv
module brx_outreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R2
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R2
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import brx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_opcode,
  input  logic [SEL_W-1:0]  in_sel,
  input  logic [DATA_W-1:0] in_rs,
  input  logic [DATA_W-1:0] in_rs2,
  input  logic [DATA_W-1:0] in_flags,
  input  logic [DATA_W-1:0] in_test,
  input  logic [DATA_W-1:0] in_addr,
  input  logic [PC_W-1:0]   in_seq_pc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_taken,
  output logic [PC_W-1:0]   out_next_pc,
  output logic              out_wr_en,
  output logic [DATA_W-1:0] out_wr_data,
  output logic              out_flags_we,
  output logic              out_c,
  output logic              out_z,
  output logic              out_n
);
  localparam int unsigned RES_W = $bits(brx_result_t);

  brx_result_t res_d;
  brx_result_t res_q;
  logic [RES_W-1:0] res_q_bits;

  brx_cond u_cond (
    .opcode   (in_opcode),
    .sel      (in_sel),
    .rs       (in_rs),
    .rs2      (in_rs2),
    .flags    (in_flags),
    .test     (in_test),
    .taken    (res_d.taken),
    .wr_en    (res_d.wr_en),
    .wr_data  (res_d.wr_data),
    .flags_we (res_d.flags_we),
    .c        (res_d.c),
    .z        (res_d.z),
    .n        (res_d.n)
  );

  brx_target u_target (
    .taken   (res_d.taken),
    .addr    (in_addr),
    .seq_pc  (in_seq_pc),
    .next_pc (res_d.next_pc)
  );

  brx_outreg #(.W(RES_W)) u_outreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_q_bits)
  );

  assign res_q        = brx_result_t'(res_q_bits);
  assign out_taken    = res_q.taken;
  assign out_next_pc  = res_q.next_pc;
  assign out_wr_en    = res_q.wr_en;
  assign out_wr_data  = res_q.wr_data;
  assign out_flags_we = res_q.flags_we;
  assign out_c        = res_q.c;
  assign out_z        = res_q.z;
  assign out_n        = res_q.n;

  // R5
  pc_page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> res_d.next_pc[PC_W-1:DATA_W] == in_seq_pc[PC_W-1:DATA_W]);
  // R5
  fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !res_d.taken |-> res_d.next_pc == in_seq_pc);
  // R6
  dec_untaken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && res_d.wr_en |-> !res_d.taken);
  // R10
  flag_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && res_d.flags_we |-> (in_opcode >= OP_ZERO_DEC) && (in_opcode <= OP_GE));
endmodule

// File: tb/test_branch_resolve_unit.sv
module test_branch_resolve_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0;
  logic [3:0]  in_sel = '0;
  logic [15:0] in_rs = '0, in_rs2 = '0, in_flags = '0, in_test = '0, in_addr = '0;
  logic [23:0] in_seq_pc = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_taken, out_wr_en, out_flags_we, out_c, out_z, out_n;
  logic [23:0] out_next_pc;
  logic [15:0] out_wr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit bp_mode = 0;
  logic [7:0] lfsr = 8'hA5;

  logic [45:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  branch_resolve_unit i_branch_resolve_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_sel(in_sel), .in_rs(in_rs), .in_rs2(in_rs2),
    .in_flags(in_flags), .in_test(in_test), .in_addr(in_addr), .in_seq_pc(in_seq_pc),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_taken(out_taken), .out_next_pc(out_next_pc),
    .out_wr_en(out_wr_en), .out_wr_data(out_wr_data),
    .out_flags_we(out_flags_we), .out_c(out_c), .out_z(out_z), .out_n(out_n)
  );

  function automatic logic [45:0] model(logic [7:0] opc, logic [3:0] sel, logic [15:0] rs,
      logic [15:0] rs2, logic [15:0] fl, logic [15:0] tr, logic [15:0] addr, logic [23:0] pc);
    logic tk = 0, we = 0, fwe = 0, c = 0, z = 0, n = 0;
    logic [15:0] wd = '0;
    logic [16:0] d;
    logic [23:0] npc;
    case (opc)
      8'h80: tk = fl[sel];
      8'h81: tk = !fl[sel];
      8'h82: tk = tr[sel];
      8'h83: tk = !tr[sel];
      8'h84, 8'h85: begin
        tk  = (opc == 8'h84) ? (rs == 0) : (rs != 0);
        we  = !tk;
        wd  = we ? rs - 16'd1 : 16'd0;
        fwe = 1; z = (rs == 0); n = rs[15]; c = we && (rs == 0);
      end
      8'h86, 8'h87, 8'h88, 8'h89: begin
        d = {1'b0, rs} - {1'b0, rs2};
        fwe = 1; c = rs < rs2; z = rs == rs2; n = d[15];
        case (opc)
          8'h86: tk = rs == rs2;
          8'h87: tk = rs != rs2;
          8'h88: tk = rs > rs2;
          default: tk = rs >= rs2;
        endcase
      end
      default: ;
    endcase
    npc = tk ? {pc[23:16], addr} : pc;
    return {tk, npc, we, wd, fwe, c, z, n};
  endfunction

  task automatic send(logic [7:0] opc, logic [3:0] sel, logic [15:0] rs, logic [15:0] rs2,
      logic [15:0] fl, logic [15:0] tr, logic [15:0] addr, logic [23:0] pc, string tag);
    @(negedge clk);
    in_opcode = opc; in_sel = sel; in_rs = rs; in_rs2 = rs2;
    in_flags = fl; in_test = tr; in_addr = addr; in_seq_pc = pc;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(model(opc, sel, rs, rs2, fl, tr, addr, pc));
    tag_q.push_back(tag);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // back-pressure driver, changes away from the sampling edge
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_mode ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      logic [45:0] act;
      act = {out_taken, out_next_pc, out_wr_en, out_wr_data, out_flags_we, out_c, out_z, out_n};
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected result act=%h exp=none", act);
      end else begin
        logic [45:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          fails++;
          $display("FAIL %s act=%h exp=%h", t, act, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R1 out_valid act=%b exp=0", out_valid); end
    checks++;
    if (in_ready !== 1'b1) begin fails++; $display("FAIL R1 in_ready act=%b exp=1", in_ready); end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int pass = 0; pass < 2; pass++) begin
      bp_mode = (pass == 1);
      // R3 flag branches, bit 0 / 7 / 15, both polarities
      send(8'h80, 4'd0,  0, 0, 16'h0001, 0, 16'h1234, 24'h5A0010, "R3 flag set bit0");
      send(8'h80, 4'd7,  0, 0, 16'hFF7F, 0, 16'h1234, 24'h5A0010, "R3 flag set bit7 clear");
      send(8'h81, 4'd15, 0, 0, 16'h7FFF, 0, 16'hBEEF, 24'h010002, "R3 flag clr bit15");
      send(8'h81, 4'd15, 0, 0, 16'h8000, 0, 16'hBEEF, 24'h010002, "R3 flag clr bit15 set");
      // R4 test-register bits
      send(8'h82, 4'd15, 0, 0, 16'hFFFF, 16'h8000, 16'h4000, 24'hC30020, "R4 tbit set bit15");
      send(8'h82, 4'd0,  0, 0, 16'hFFFF, 16'hFFFE, 16'h4000, 24'hC30020, "R4 tbit set bit0 clear");
      send(8'h83, 4'd3,  0, 0, 16'h0000, 16'hFFF7, 16'h0042, 24'h7F1000, "R4 tbit clr bit3");
      send(8'h83, 4'd3,  0, 0, 16'h0000, 16'h0008, 16'h0042, 24'h7F1000, "R4 tbit clr bit3 set");
      // R6 branch on zero with decrement
      send(8'h84, 0, 16'h0000, 0, 0, 0, 16'hAAAA, 24'h120005, "R6 zero taken");
      send(8'h84, 0, 16'h0001, 0, 0, 0, 16'hAAAA, 24'h120005, "R6 one decrements");
      send(8'h84, 0, 16'h8000, 0, 0, 0, 16'hAAAA, 24'h120005, "R6 sign bit N");
      // R7 branch on nonzero with decrement
      send(8'h85, 0, 16'h0005, 0, 0, 0, 16'h5555, 24'hFF0100, "R7 nonzero taken");
      send(8'h85, 0, 16'h0000, 0, 0, 0, 16'h5555, 24'hFF0100, "R7 zero wraps with borrow");
      // R8 equality
      send(8'h86, 0, 16'h1234, 16'h1234, 0, 0, 16'h0F0F, 24'h030300, "R8 eq equal");
      send(8'h86, 0, 16'h0001, 16'h0002, 0, 0, 16'h0F0F, 24'h030300, "R8 eq less");
      send(8'h87, 0, 16'h0003, 16'h0002, 0, 0, 16'h0F0F, 24'h030300, "R8 ne greater");
      send(8'h87, 0, 16'h7777, 16'h7777, 0, 0, 16'h0F0F, 24'h030300, "R8 ne equal");
      // R9 unsigned ordering
      send(8'h88, 0, 16'h8000, 16'h0001, 0, 0, 16'h2222, 24'h440000, "R9 gt unsigned");
      send(8'h88, 0, 16'h0010, 16'h0010, 0, 0, 16'h2222, 24'h440000, "R9 gt equal");
      send(8'h89, 0, 16'h0010, 16'h0010, 0, 0, 16'h2222, 24'h440000, "R9 ge equal");
      send(8'h89, 0, 16'h0001, 16'h8000, 0, 0, 16'h2222, 24'h440000, "R9 ge less");
      // R10 / R11 opcode outside the group
      send(8'h45, 4'd2, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 16'h9999, 24'hABCDEF, "R10 other opcode");
      send(8'h8A, 4'd2, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 16'h9999, 24'hABCDEF, "R10 just past group");
      // R5 upper byte retained on taken local branch
      send(8'h80, 4'd1, 0, 0, 16'h0002, 0, 16'hFFFF, 24'hEE0000, "R5 page byte kept");
    end

    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 results outstanding act=%0d exp=0", exp_q.size());
    end
    finish_run();
  end
endmodule